// File: doc/BRIEF.md
# Compressed Paired-Access Expander

This block is a purely combinational decode stage for a 32-bit core that accepts 16-bit instructions. It looks at one 16-bit instruction word and recognises four compressed doubleword memory forms. Two of them address memory relative to the stack pointer (x2). The other two take their base and data registers from the eight-entry compressed register set. For each recognised form, the block emits the equivalent full-width instruction word: either a paired load (two consecutive 32-bit words into an even/odd register pair) or a paired store. Both use funct3 `011`.

The offset bits in a compressed form are scattered across the instruction. The block gathers them into an unsigned byte offset that is a multiple of 8 and zero-extends it to 12 bits. It then places that offset into the I-type field layout (load) or the split S-type field layout (store). It also flags an instruction as illegal when its data register has an odd index, because a pair must start on an even register.

The expander only responds when the extension enable input is high and the build-time configuration allows it. That configuration is: a 32-bit core, the base compressed extension present, and the compressed single-precision float loads and stores absent, since those use the same opcode space. When the match flag is low, the output word has no meaning.

Top module: `cpair_expand`

## Requirements
- R1: A stack-relative load (bits 15:13 = `011`, bits 1:0 = `10`, enable high) sets match. Its byte offset is bit12→off[5], bits 6:5→off[4:3], bits 4:2→off[8:6]. The output word is {imm[11:0], rs1=2, `011`, rd=bits 11:7, `0000011`}.
- R2: A stack-relative store (bits 15:13 = `111`, bits 1:0 = `10`) sets match. Its byte offset is bits 12:10→off[5:3], bits 9:7→off[8:6]. The output word is {imm[11:5], rs2=bits 6:2, rs1=2, `011`, imm[4:0], `0100011`}.
- R3: A register-based load (bits 15:13 = `011`, bits 1:0 = `00`) sets match. Its byte offset is bits 12:10→off[5:3], bits 6:5→off[7:6]. The base register comes from bits 9:7, the destination from bits 4:2, and the output uses the load layout of R1.
- R4: A register-based store (bits 15:13 = `111`, bits 1:0 = `00`) uses the same offset and base fields as R3. Bits 4:2 give the data register, and the output uses the store layout of R2.
- R5: A 3-bit compressed register field r selects register 8+r (binary `01` prefixed).
- R6: In a matched load, an odd destination register index sets illegal. An even one leaves it clear.
- R7: In a matched store, an odd data register index sets illegal. An even one leaves it clear.
- R8: With enable low, match and illegal are both 0 for every instruction.
- R9: Any instruction outside the four forms gives match 0 and illegal 0.
- R10: Offsets are unsigned multiples of 8. Immediate bits 2:0 are always 0, and every bit above the form's largest offset bit is 0 (above bit 8 for stack forms, above bit 7 for register forms).
- R11: Illegal is never high while match is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cinstr_i | input | 16 | Compressed instruction to examine |
| pair_en_i | input | 1 | Extension enable |
| match_o | output | 1 | One of the four forms was recognised |
| illegal_o | output | 1 | Recognised form names an odd data register |
| word_o | output | 32 | Expanded 32-bit instruction (valid when match_o) |

## Verification
The bench covers the following corner cases, and what a faulty design would do on each:

- **All offset bits set.** This catches a field swap or shift, for example offset bits 4:3 and 8:6 exchanged in the stack load. Such a design would produce a wrong but well-formed immediate.
- **Odd data registers in every form.** For compressed register fields, only bit 2 of the instruction decides parity. A design that tested the wrong bit would either pass odd pairs or reject good ones.
- **Store immediate split.** A store immediate is split around the register fields. A design that reused the load layout would leave stray bits in the rs2 field.
- **Neighbouring quadrant and funct3 patterns.** Sweeping these together with enable low shows whether a design matches too widely or ignores the enable.

// File: rtl/cpair_expand.sv
module cpair_expand #(
  parameter int XLEN   = 32,
  parameter bit HAS_CA = 1'b1,
  parameter bit HAS_CF = 1'b0
) (
  input  logic [15:0] cinstr_i,
  input  logic        pair_en_i,
  output logic        match_o,
  output logic        illegal_o,
  output logic [31:0] word_o
);

  localparam bit         ALLOWED   = (XLEN == 32) && HAS_CA && !HAS_CF;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [2:0] F3_PAIR   = 3'b011;
  localparam logic [4:0] REG_SP    = 5'd2;
  localparam logic [1:0] CREG_PFX  = 2'b01;

  logic sp_quad, rg_quad, ld_f3, st_f3;
  logic sp_ld, sp_st, rg_ld, rg_st;
  logic [11:0] imm_spl, imm_sps, imm_rg, imm;
  logic [4:0]  creg_lo, creg_hi;
  logic [4:0]  rs1, data_reg;
  logic        is_store;

  assign sp_quad = cinstr_i[1:0] == 2'b10;
  assign rg_quad = cinstr_i[1:0] == 2'b00;
  assign ld_f3   = cinstr_i[15:13] == 3'b011;
  assign st_f3   = cinstr_i[15:13] == 3'b111;

  assign sp_ld = ALLOWED && pair_en_i && sp_quad && ld_f3;
  assign sp_st = ALLOWED && pair_en_i && sp_quad && st_f3;
  assign rg_ld = ALLOWED && pair_en_i && rg_quad && ld_f3;
  assign rg_st = ALLOWED && pair_en_i && rg_quad && st_f3;

  assign imm_spl = {3'b000, cinstr_i[4:2], cinstr_i[12], cinstr_i[6:5], 3'b000};
  assign imm_sps = {3'b000, cinstr_i[9:7], cinstr_i[12:10], 3'b000};
  assign imm_rg  = {4'b0000, cinstr_i[6:5], cinstr_i[12:10], 3'b000};

  assign creg_lo = {CREG_PFX, cinstr_i[4:2]};
  assign creg_hi = {CREG_PFX, cinstr_i[9:7]};

  always_comb begin
    imm      = imm_rg;
    rs1      = creg_hi;
    data_reg = creg_lo;
    if (sp_ld) begin
      imm      = imm_spl;
      rs1      = REG_SP;
      data_reg = cinstr_i[11:7];
    end else if (sp_st) begin
      imm      = imm_sps;
      rs1      = REG_SP;
      data_reg = cinstr_i[6:2];
    end
  end

  assign is_store  = sp_st || rg_st;
  assign match_o   = sp_ld || sp_st || rg_ld || rg_st;
  assign illegal_o = match_o && data_reg[0];

  assign word_o = is_store
    ? {imm[11:5], data_reg, rs1, F3_PAIR, imm[4:0], OP_STORE}
    : {imm, rs1, F3_PAIR, data_reg, OP_LOAD};

endmodule

// File: rtl/cpair_expand_chk.sv
module cpair_expand_chk (
  input logic [15:0] cinstr_i,
  input logic        pair_en_i,
  input logic        match_o,
  input logic        illegal_o,
  input logic [31:0] word_o
);

  always_comb begin
    p_illegal_needs_match_r11: assert (!illegal_o || match_o);
    p_disabled_quiet_r8: assert (pair_en_i || (!match_o && !illegal_o));
    if (match_o) begin
      p_pair_funct3_r1: assert (word_o[14:12] == 3'b011);
      p_known_opcode_r2: assert (word_o[6:0] == 7'b0000011 || word_o[6:0] == 7'b0100011);
      if (cinstr_i[1:0] == 2'b00)
        p_creg_base_range_r5: assert (word_o[19:15] >= 5'd8 && word_o[19:15] <= 5'd15);
      if (cinstr_i[1:0] == 2'b10)
        p_sp_base_r1: assert (word_o[19:15] == 5'd2);
      if (word_o[6:0] == 7'b0000011) begin
        p_load_even_rd_r6: assert (illegal_o == word_o[7]);
        p_load_imm_low_r10: assert (word_o[22:20] == 3'b000 && word_o[31:29] == 3'b000);
      end else begin
        p_store_even_src_r7: assert (illegal_o == word_o[20]);
        p_store_imm_low_r10: assert (word_o[9:7] == 3'b000 && word_o[31:29] == 3'b000);
      end
    end else begin
      p_nomatch_outside_r9: assert (!(pair_en_i && (cinstr_i[14:13] == 2'b11) && !cinstr_i[0]));
    end
  end

endmodule

bind cpair_expand cpair_expand_chk u_chk (
  .cinstr_i (cinstr_i),
  .pair_en_i(pair_en_i),
  .match_o  (match_o),
  .illegal_o(illegal_o),
  .word_o   (word_o)
);

// File: tb/cpair_expand_test.sv
module cpair_expand_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ins = 16'h0000;
  logic        en  = 1'b0;
  logic        m, il;
  logic [31:0] w;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpair_expand uut (.cinstr_i(ins), .pair_en_i(en), .match_o(m), .illegal_o(il), .word_o(w));

  // Reference: decode by meaning, build word from integer offset and register numbers.
  function automatic void ref_model(input logic [15:0] c, input logic e,
                                    output logic rm, output logic ril,
                                    output logic [31:0] rw, output string tag);
    int off, base, dreg;
    bit st;
    rm = 1'b0; ril = 1'b0; rw = '0; tag = "R9";
    off = 0; base = 0; dreg = 0; st = 0;
    if (!e) begin tag = "R8"; return; end
    if (c[1:0] == 2'b10 && c[15:13] == 3'b011) begin
      off = c[12]*32 + c[6:5]*8 + c[4:2]*64; base = 2; dreg = c[11:7]; st = 0; tag = "R1";
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b111) begin
      off = c[12:10]*8 + c[9:7]*64; base = 2; dreg = c[6:2]; st = 1; tag = "R2";
    end else if (c[1:0] == 2'b00 && c[15:13] == 3'b011) begin
      off = c[12:10]*8 + c[6:5]*64; base = 8 + c[9:7]; dreg = 8 + c[4:2]; st = 0; tag = "R3";
    end else if (c[1:0] == 2'b00 && c[15:13] == 3'b111) begin
      off = c[12:10]*8 + c[6:5]*64; base = 8 + c[9:7]; dreg = 8 + c[4:2]; st = 1; tag = "R4";
    end else return;
    rm  = 1'b1;
    ril = (dreg % 2) == 1;
    if (st) rw = (off / 32) * (1 << 25) + dreg * (1 << 20) + base * (1 << 15)
                 + 3 * (1 << 12) + (off % 32) * (1 << 7) + 35;
    else    rw = off * (1 << 20) + base * (1 << 15) + 3 * (1 << 12) + dreg * (1 << 7) + 3;
  endfunction

  task automatic check(input string req);
    logic em, eil; logic [31:0] ew; string tag;
    ref_model(ins, en, em, eil, ew, tag);
    n_chk++;
    if (m !== em || il !== eil || (em && w !== ew)) begin
      n_bad++;
      $display("FAIL %s/%s ins=%h en=%0b: got m=%0b il=%0b w=%h, exp m=%0b il=%0b w=%h",
               req, tag, ins, en, m, il, w, em, eil, ew);
    end
  endtask

  task automatic apply(input logic [15:0] c, input logic e, input string req);
    @(posedge clk);
    ins = c; en = e;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (m !== 1'b0 || il !== 1'b0) begin
      n_bad++; $display("FAIL R8 reset state: got m=%0b il=%0b, exp 0 0", m, il);
    end
    rst = 1'b0;
    // R1 stack load: all offset bits set, rd=x10 (offset 0x1F8)
    apply({3'b011, 1'b1, 5'd10, 2'b11, 3'b111, 2'b10}, 1'b1, "R1");
    apply({3'b011, 1'b1, 5'd10, 2'b00, 3'b000, 2'b10}, 1'b1, "R1");
    apply({3'b011, 1'b0, 5'd4,  2'b01, 3'b100, 2'b10}, 1'b1, "R10");
    // R6 odd rd
    apply({3'b011, 1'b0, 5'd11, 2'b00, 3'b000, 2'b10}, 1'b1, "R6");
    // R2 stack store
    apply({3'b111, 3'b111, 3'b111, 5'd6, 2'b10}, 1'b1, "R2");
    apply({3'b111, 3'b001, 3'b100, 5'd20, 2'b10}, 1'b1, "R2");
    apply({3'b111, 3'b000, 3'b000, 5'd7, 2'b10}, 1'b1, "R7");
    // R3/R4 register forms
    apply({3'b011, 3'b111, 3'b000, 2'b11, 3'b110, 2'b00}, 1'b1, "R3");
    apply({3'b011, 3'b010, 3'b111, 2'b10, 3'b011, 2'b00}, 1'b1, "R6");
    apply({3'b111, 3'b101, 3'b011, 2'b01, 3'b000, 2'b00}, 1'b1, "R4");
    apply({3'b111, 3'b000, 3'b000, 2'b00, 3'b111, 2'b00}, 1'b1, "R7");
    apply({3'b011, 3'b000, 3'b000, 2'b00, 3'b000, 2'b00}, 1'b1, "R5");
    // R8 enable low, R9 neighbours
    apply({3'b011, 1'b1, 5'd10, 2'b11, 3'b111, 2'b10}, 1'b0, "R8");
    apply({3'b111, 3'b000, 3'b000, 2'b00, 3'b111, 2'b00}, 1'b0, "R8");
    apply({3'b010, 1'b0, 5'd10, 2'b00, 3'b000, 2'b10}, 1'b1, "R9");
    apply({3'b011, 1'b0, 5'd10, 2'b00, 3'b000, 2'b01}, 1'b1, "R9");
    apply({3'b101, 3'b000, 3'b000, 2'b00, 3'b000, 2'b00}, 1'b1, "R9");
    apply(16'h0000, 1'b1, "R9");
    // Exhaustive sweep with enable high, and a partial sweep with it low (R1-style mix)
    for (int i = 0; i < 65536; i++) apply(i[15:0], 1'b1, "SWEEP");
    for (int i = 0; i < 8192; i++) apply(16'($urandom()), 1'b0, "R8");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule